// File: doc/BRIEF.md
# Semi-Digital Hit Encoder with Zero Suppression

This block sits behind the discriminators of a 64-channel front end. Each channel has three comparators, at a low, a medium and a high threshold. The block synchronises their outputs and holds every pulse it sees until the next evaluation. It then folds each channel's three bits into a 2-bit level code.

A strobe from an internal divider fires once every `PERIOD` cycles. On that strobe the block asks one question: did any channel's low-threshold comparator fire during the period? If so, it writes the 64 codes and a free-running timestamp as one frame into an on-chip event memory of 128 frames. If not, the period leaves no trace in the memory.

A downstream reader drains the frames in arrival order through a valid/ready port. When the memory is full, new frames are dropped and a full flag stays high until a frame is read.

Top module: `semidig_hit_encoder`

## Requirements
- R1: After reset, `rdValid` and `memFull` are both 0.
- R2: Each channel's code is 2'b11 when its high bit is set, otherwise 2'b10 when its medium bit is set, otherwise 2'b01 when its low bit is set, otherwise 2'b00. This rule also covers non-monotonic patterns such as high alone. Channel i occupies bits [2i+1:2i] of `rdCodes`.
- R3: The evaluation strobe falls on every `PERIOD`-th rising edge counted from reset release. The first one is edge `PERIOD`.
- R4: A frame is written only if at least one channel's low bit is set at the strobe. A period in which only medium or high comparators fired writes nothing.
- R5: An input pulse of at least one cycle counts toward the next strobe if it reaches the block before that strobe and after the previous one. It passes a two-flip-flop synchroniser on the way. Pulses within one period are ORed per comparator, and the held bits clear at each strobe.
- R6: `rdStamp` holds the free-running cycle count at the storing strobe. That count equals the number of rising edges since reset release minus one, modulo 2^`TS_W`.
- R7: The memory holds `DEPTH` (128) frames. With `DEPTH` frames stored, `memFull` is 1 and a further qualifying frame is dropped.
- R8: `rdValid` is 1 exactly when frames are stored. `rdCodes`/`rdStamp` show the oldest frame, and a rising edge with `rdValid` and `rdReady` both high removes it (first in, first out).
- R9: `memFull` returns to 0 on the edge that removes a frame from a full memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| discLo | input | NUM_CH | Low-threshold comparator outputs, one per channel |
| discMid | input | NUM_CH | Medium-threshold comparator outputs |
| discHi | input | NUM_CH | High-threshold comparator outputs |
| rdReady | input | 1 | Reader accepts the current frame |
| rdValid | output | 1 | A stored frame is presented |
| rdCodes | output | 2*NUM_CH | 2-bit level codes of the oldest frame |
| rdStamp | output | TS_W | Timestamp of the oldest frame |
| memFull | output | 1 | Event memory holds DEPTH frames |

## Verification
Some properties are checked on every cycle:
- the stored-frame count never exceeds the depth;
- strobes never fall on adjacent cycles;
- a frame is written only while some low bit is held;
- no frame is removed from an empty memory;
- the full flag rises only on a store.

The bench covers the behaviour that needs a model of the whole period. This covers:
- the code value of each channel, including non-monotonic patterns;
- pulses at different times in one period merging into one code;
- timestamps landing on strobe edges;
- whole frames being discarded;
- frames dropped while full;
- the order of frames at readout.

// File: rtl/hitenc_pkg.sv
package hitenc_pkg;

  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic evalNow;     // end of evaluation period
    logic storeFrame;  // write the accumulated frame
    logic popFrame;    // reader takes the oldest frame
  } hitenc_strobe_t;

  // Highest asserted threshold wins
  function automatic logic [1:0] levelCode(input logic lo, input logic mid, input logic hi);
    logic [1:0] code;
    if (hi)       code = 2'b11;
    else if (mid) code = 2'b10;
    else if (lo)  code = 2'b01;
    else          code = 2'b00;
    return code;
  endfunction

endpackage

// File: rtl/hitenc_datapath.sv
module hitenc_datapath
  import hitenc_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 128,
  parameter int TS_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     discLo,
  input  logic [NUM_CH-1:0]     discMid,
  input  logic [NUM_CH-1:0]     discHi,
  input  hitenc_strobe_t        strobe,
  output logic                  anyLo,
  output logic [2*NUM_CH-1:0]   rdCodes,
  output logic [TS_W-1:0]       rdStamp
);

  localparam int CODE_W  = 2 * NUM_CH;
  localparam int FRAME_W = CODE_W + TS_W;
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVLS    = 3;

  logic [LVLS-1:0][NUM_CH-1:0] rawIn, syncA, syncB, sticky, accum;
  logic [CODE_W-1:0]           frameCodes;
  logic [TS_W-1:0]             tsCnt;
  logic [AW-1:0]               wrPtr, rdPtr;
  logic [FRAME_W-1:0]          mem [DEPTH];
  logic [FRAME_W-1:0]          rdWord;

  assign rawIn = {discHi, discMid, discLo};

  // Two-stage synchroniser, then hold every pulse until the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA  <= '0;
      syncB  <= '0;
      sticky <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (strobe.evalNow) sticky <= '0;
      else                sticky <= accum;
    end
  end

  assign accum = sticky | syncB;
  assign anyLo = |accum[0];

  // Per-channel 3-to-2 level encoder
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_enc
    assign frameCodes[2*ch +: 2] = levelCode(accum[0][ch], accum[1][ch], accum[2][ch]);
  end

  // Free-running timestamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsCnt <= '0;
    else        tsCnt <= tsCnt + 1'b1;
  end

  // Event memory pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.storeFrame)
        wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strobe.popFrame)
        rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeFrame) mem[wrPtr] <= {tsCnt, frameCodes};
  end

  assign rdWord  = mem[rdPtr];
  assign rdCodes = rdWord[CODE_W-1:0];
  assign rdStamp = rdWord[FRAME_W-1:CODE_W];

  // R4
  stored_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.storeFrame |-> (anyLo && strobe.evalNow));

endmodule

// File: rtl/hitenc_ctrl.sv
module hitenc_ctrl
  import hitenc_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int PERIOD = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           anyLo,
  input  logic           rdReady,
  output hitenc_strobe_t strobe,
  output logic           rdValid,
  output logic           memFull
);

  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] periodCnt;
  logic [CW-1:0] fillCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           periodCnt <= '0;
    else if (periodCnt == PW'(PERIOD-1))  periodCnt <= '0;
    else                                  periodCnt <= periodCnt + 1'b1;
  end

  assign memFull = (fillCnt == CW'(DEPTH));
  assign rdValid = (fillCnt != '0);

  assign strobe.evalNow    = (periodCnt == PW'(PERIOD-1));
  assign strobe.storeFrame = strobe.evalNow && anyLo && !memFull;
  assign strobe.popFrame   = rdValid && rdReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fillCnt <= '0;
    else begin
      case ({strobe.storeFrame, strobe.popFrame})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillCnt <= CW'(DEPTH));

  // R3
  eval_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evalNow |=> !strobe.evalNow);

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.popFrame |-> (fillCnt != '0));

  // R7
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memFull) |-> $past(strobe.storeFrame));

endmodule

// File: rtl/semidig_hit_encoder.sv
module semidig_hit_encoder
  import hitenc_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 128,
  parameter int TS_W   = 16,
  parameter int PERIOD = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   discLo,
  input  logic [NUM_CH-1:0]   discMid,
  input  logic [NUM_CH-1:0]   discHi,
  input  logic                rdReady,
  output logic                rdValid,
  output logic [2*NUM_CH-1:0] rdCodes,
  output logic [TS_W-1:0]     rdStamp,
  output logic                memFull
);

  hitenc_strobe_t strobe;
  logic           anyLo;

  hitenc_ctrl #(.DEPTH(DEPTH), .PERIOD(PERIOD)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .anyLo   (anyLo),
    .rdReady (rdReady),
    .strobe  (strobe),
    .rdValid (rdValid),
    .memFull (memFull)
  );

  hitenc_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .TS_W(TS_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .discLo  (discLo),
    .discMid (discMid),
    .discHi  (discHi),
    .strobe  (strobe),
    .anyLo   (anyLo),
    .rdCodes (rdCodes),
    .rdStamp (rdStamp)
  );

endmodule

// File: tb/semidig_hit_encoder_test.sv
`timescale 1ns/1ps
module semidig_hit_encoder_test;

  localparam int NUM_CH = 64;
  localparam int DEPTH  = 128;
  localparam int TS_W   = 16;
  localparam int PERIOD = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] discLo = '0, discMid = '0, discHi = '0;
  logic rdReady = 1'b0;
  logic rdValid, memFull;
  logic [2*NUM_CH-1:0] rdCodes;
  logic [TS_W-1:0] rdStamp;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  bit done = 0;

  logic [2*NUM_CH-1:0] expCodes [$];
  logic [TS_W-1:0]     expStamp [$];

  always #2.5 clk = ~clk;

  semidig_hit_encoder #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .TS_W(TS_W), .PERIOD(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .discLo(discLo), .discMid(discMid), .discHi(discHi),
    .rdReady(rdReady), .rdValid(rdValid), .rdCodes(rdCodes), .rdStamp(rdStamp),
    .memFull(memFull)
  );

  always @(posedge clk) if (rst_n) edgeCnt <= edgeCnt + 1;

  function automatic logic [2*NUM_CH-1:0] refCodes(input logic [NUM_CH-1:0] lo,
                                                   input logic [NUM_CH-1:0] mid,
                                                   input logic [NUM_CH-1:0] hi);
    logic [2*NUM_CH-1:0] r;
    for (int i = 0; i < NUM_CH; i++) begin
      r[2*i +: 2] = hi[i] ? 2'd3 : mid[i] ? 2'd2 : lo[i] ? 2'd1 : 2'd0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitMod(input int r);
    @(negedge clk);
    while (edgeCnt % PERIOD != r) @(negedge clk);
  endtask

  // Two pulses inside one period, then wait past the strobe and check flags
  task automatic runPeriod(input logic [NUM_CH-1:0] lo1, input logic [NUM_CH-1:0] mid1,
                           input logic [NUM_CH-1:0] hi1, input logic [NUM_CH-1:0] lo2,
                           input logic [NUM_CH-1:0] mid2, input logic [NUM_CH-1:0] hi2);
    int strobeEdge;
    logic [NUM_CH-1:0] lo, mid, hi;
    waitMod(8);
    strobeEdge = (edgeCnt / PERIOD + 1) * PERIOD;
    discLo = lo1; discMid = mid1; discHi = hi1;
    @(negedge clk);
    discLo = '0; discMid = '0; discHi = '0;
    waitMod(16);
    discLo = lo2; discMid = mid2; discHi = hi2;
    @(negedge clk);
    discLo = '0; discMid = '0; discHi = '0;
    lo = lo1 | lo2; mid = mid1 | mid2; hi = hi1 | hi2;
    if ((|lo) && expCodes.size() < DEPTH) begin
      expCodes.push_back(refCodes(lo, mid, hi));
      expStamp.push_back(TS_W'(strobeEdge - 1));
    end
    waitMod(2);
    // R7 full flag tracks the model occupancy
    check(memFull == (expCodes.size() == DEPTH), "R7 memFull", memFull, expCodes.size() == DEPTH);
    // R4 R8 valid reflects whether anything was stored
    check(rdValid == (expCodes.size() != 0), "R4/R8 rdValid", rdValid, expCodes.size() != 0);
  endtask

  task automatic readOne(input string req);
    logic [2*NUM_CH-1:0] ec;
    logic [TS_W-1:0] es;
    ec = expCodes.pop_front();
    es = expStamp.pop_front();
    rdReady = 1'b1;
    check(rdValid === 1'b1, "R8 valid before pop", rdValid, 1);
    check(rdCodes === ec, {req, " codes"}, rdCodes, ec);
    // R6 timestamp at strobe edge
    check(rdStamp === es, "R6 stamp", rdStamp, es);
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  initial begin
    logic [NUM_CH-1:0] a, b, c;
    void'($urandom(1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdValid === 1'b0, "R1 rdValid", rdValid, 0);
    check(memFull === 1'b0, "R1 memFull", memFull, 0);
    rst_n = 1'b1;

    // R4 medium/high only: discarded (first period, strobe at edge PERIOD)
    runPeriod('0, 64'h00F0, 64'h0100, '0, 64'h8000_0000_0000_0000, '0);
    check(rdValid === 1'b0, "R4 no-low period discarded", rdValid, 0);

    // R2 all code values, including high alone on ch63 and medium alone on ch7
    runPeriod(64'h0000_0000_0000_0007, 64'h0000_0000_0000_0086, 64'h8000_0000_0000_0004, '0, '0, '0);
    // R5 sticky: low on ch10 early, medium on ch10 later -> code 10; ch20 low then high
    runPeriod(64'h0010_0400, '0, '0, '0, 64'h0400, 64'h0010_0000);
    // R3 R6 first two stored frames carry stamps 2*PERIOD-1 and 3*PERIOD-1
    check(expStamp[0] == TS_W'(2*PERIOD-1), "R3 strobe edge model", expStamp[0], 2*PERIOD-1);
    readOne("R2 level encoding");
    readOne("R5 sticky merge");
    check(rdValid === 1'b0, "R8 empty after drain", rdValid, 0);

    // Random fill, mixing discarded periods, until the memory is full
    while (expCodes.size() < DEPTH) begin
      a = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 5 == 0) a = '0;
      b = a & {$urandom, $urandom};
      c = (b & {$urandom, $urandom}) | ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      runPeriod(a, b, c, '0, {$urandom, $urandom} & {$urandom, $urandom}, '0);
    end
    // R7 one more qualifying frame is dropped while full
    runPeriod(64'h1, 64'h1, '0, '0, '0, '0);
    check(memFull === 1'b1, "R7 still full after drop", memFull, 1);

    // R9 one read frees space
    readOne("R8 fifo order");
    check(memFull === 1'b0, "R9 full clears on pop", memFull, 0);

    // Drain with random gaps
    while (expCodes.size() != 0) begin
      repeat ($urandom % 3) @(negedge clk);
      readOne("R8 fifo order");
    end
    @(negedge clk);
    check(rdValid === 1'b0, "R8 empty at end", rdValid, 0);
    check(memFull === 1'b0, "R7 not full at end", memFull, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule